// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide register front end of an eight-line interrupt controller. It has a chip select, separate read and write strobes and one address bit. Writes to address 0 are split three ways by bits 4 and 3 of the data. A byte with bit 4 set restarts the controller and opens a counted setup sequence. A byte with only bit 3 set updates the read and poll options. A byte with both bits clear is handed on as an end-of-interrupt or rotate command. Writes to address 1 are routed by the setup step: the vector base, a byte that is only counted, an optional mode byte, and in normal operation the line mask.

The neighbouring priority and request logic receives the stored configuration and one-cycle strobes: a restart strobe, a command strobe carrying its code and level, and a poll acknowledge naming the line that was taken. Reads are registered and appear one cycle after the read strobe. A read from address 0 returns the request register or the in-service register, depending on a stored selector. A read from address 1 returns the mask. When a poll is armed, the next read returns the winning line instead and disarms the poll. The acknowledge vector is formed from the stored base and the line number supplied by the priority logic.

Top module: `intc_cmd_regs`

## Requirements
- R1: After reset, rdata, mask, vec_base, read_isr, spec_mask, poll_armed, fnest and auto_eoi are all 0.
- R2: A selected write to address 0 with data bit 4 set pulses init_pulse for one cycle, starting on the next clock. It clears mask, read_isr, spec_mask, poll_armed, fnest and auto_eoi, and enters setup step 1. Data bit 0 is recorded as "mode byte expected".
- R3: In setup step 1, a write to address 1 sets vec_base to the data with bits 2:0 cleared and leaves mask unchanged.
- R4: In setup step 2, a write to address 1 goes to step 3 if a mode byte is expected and otherwise back to normal operation. The byte itself changes no output.
- R5: In setup step 3, a write to address 1 sets fnest from data bit 4 and auto_eoi from data bit 1, then returns to normal operation.
- R6: In normal operation, a write to address 1 loads mask. mask changes only on a selected write.
- R7: A write to address 0 with bit 4 clear and bit 3 set arms the poll if bit 2 is set. It copies bit 0 into read_isr only if bit 1 is set, and bit 5 into spec_mask only if bit 6 is set.
- R8: A write to address 0 with bits 4 and 3 both clear pulses cmd_stb for one cycle, with cmd_code equal to data bits 7:5 and cmd_level equal to data bits 2:0.
- R9: With no poll armed, a read returns on rdata one cycle later the mask for address 1, and for address 0 isr_reg when read_isr is 1 or req_reg when it is 0.
- R10: With a poll armed, the next read returns {5'b0, poll_line} when poll_hit is 1, and 0x07 otherwise. It pulses poll_ack with poll_ack_line only on a hit, and clears poll_armed.
- R11: If a poll read and a write that arms a poll fall in the same cycle, the read is served as a poll and poll_armed stays 1.
- R12: ack_vec equals vec_base ORed with ack_line, combinationally.
- R13: With sel low, wr and rd have no effect: no strobe and no change to any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_reg | input | 8 | Request register from the request block |
| isr_reg | input | 8 | In-service register from the priority block |
| poll_hit | input | 1 | A line currently wins arbitration |
| poll_line | input | 3 | Winning line number |
| ack_line | input | 3 | Line being acknowledged |
| ack_vec | output | 8 | Vector number for the acknowledged line |
| init_pulse | output | 1 | Restart strobe, also drops the interrupt output |
| cmd_stb | output | 1 | End-of-interrupt or rotate command strobe |
| cmd_code | output | 3 | Command code |
| cmd_level | output | 3 | Command line level |
| poll_ack | output | 1 | Poll read took a line |
| poll_ack_line | output | 3 | Line taken by the poll read |
| mask | output | 8 | Line mask register |
| vec_base | output | 8 | Vector base, bits 2:0 zero |
| fnest | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| read_isr | output | 1 | Read selector for address 0 |
| spec_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | A poll read is pending |

## Verification
A poll read and a write to address 0 that arms a new poll can fall in the same clock. The first disarms the poll flag and the second sets it. The bench raises read and write strobes together while a poll is armed and a line is winning. It expects the poll line on rdata one cycle later and poll_armed still high. A plain read that follows must then be served as a poll and must disarm it.

// File: rtl/intc_cmd_regs.sv
module intc_cmd_regs #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic          rd,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] req_reg,
  input  logic [DW-1:0] isr_reg,
  input  logic          poll_hit,
  input  logic [LW-1:0] poll_line,
  input  logic [LW-1:0] ack_line,
  output logic [DW-1:0] ack_vec,
  output logic          init_pulse,
  output logic          cmd_stb,
  output logic [2:0]    cmd_code,
  output logic [LW-1:0] cmd_level,
  output logic          poll_ack,
  output logic [LW-1:0] poll_ack_line,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic          fnest,
  output logic          auto_eoi,
  output logic          read_isr,
  output logic          spec_mask,
  output logic          poll_armed
);

  localparam logic [DW-1:0] BASE_MASK = {{(DW-LW){1'b1}}, {LW{1'b0}}};
  localparam logic [DW-1:0] NO_LINE   = DW'((1 << LW) - 1);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_SKIP, ST_MODE} step_t;

  step_t step;
  logic  want_mode;

  wire wr_en  = sel & wr;
  wire rd_en  = sel & rd;
  wire w_init = wr_en & ~a0 & wdata[4];
  wire w_opt  = wr_en & ~a0 & ~wdata[4] & wdata[3];
  wire w_cmd  = wr_en & ~a0 & ~wdata[4] & ~wdata[3];
  wire w_data = wr_en & a0;

  assign ack_vec = vec_base | DW'(ack_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step          <= ST_RUN;
      want_mode     <= 1'b0;
      rdata         <= '0;
      init_pulse    <= 1'b0;
      cmd_stb       <= 1'b0;
      cmd_code      <= '0;
      cmd_level     <= '0;
      poll_ack      <= 1'b0;
      poll_ack_line <= '0;
      mask          <= '0;
      vec_base      <= '0;
      fnest         <= 1'b0;
      auto_eoi      <= 1'b0;
      read_isr      <= 1'b0;
      spec_mask     <= 1'b0;
      poll_armed    <= 1'b0;
    end else begin
      init_pulse <= 1'b0;
      cmd_stb    <= 1'b0;
      poll_ack   <= 1'b0;

      if (rd_en) begin
        if (poll_armed) begin
          rdata         <= poll_hit ? DW'(poll_line) : NO_LINE;
          poll_ack      <= poll_hit;
          poll_ack_line <= poll_line;
          poll_armed    <= 1'b0;
        end else begin
          rdata <= a0 ? mask : (read_isr ? isr_reg : req_reg);
        end
      end

      if (w_init) begin
        step       <= ST_BASE;
        want_mode  <= wdata[0];
        init_pulse <= 1'b1;
        mask       <= '0;
        vec_base   <= '0;
        fnest      <= 1'b0;
        auto_eoi   <= 1'b0;
        read_isr   <= 1'b0;
        spec_mask  <= 1'b0;
        poll_armed <= 1'b0;
      end

      if (w_opt) begin
        if (wdata[2]) poll_armed <= 1'b1;
        if (wdata[1]) read_isr   <= wdata[0];
        if (wdata[6]) spec_mask  <= wdata[5];
      end

      if (w_cmd) begin
        cmd_stb   <= 1'b1;
        cmd_code  <= wdata[7:5];
        cmd_level <= wdata[LW-1:0];
      end

      if (w_data) begin
        case (step)
          ST_RUN:  mask <= wdata;
          ST_BASE: begin
            vec_base <= wdata & BASE_MASK;
            step     <= ST_SKIP;
          end
          ST_SKIP: step <= want_mode ? ST_MODE : ST_RUN;
          ST_MODE: begin
            fnest    <= wdata[4];
            auto_eoi <= wdata[1];
            step     <= ST_RUN;
          end
          default: step <= ST_RUN;
        endcase
      end
    end
  end

  // R2: a restart write leaves mask cleared and strobes init_pulse
  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel && wr && !a0 && wdata[4]) |-> (init_pulse && mask == '0 && !poll_armed));

  // R6: mask holds without a selected write
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel && wr) |-> $stable(mask));

  // R8: a command strobe only follows a command-format write
  a_r8_cmd_src: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(sel && wr && !a0 && wdata[4:3] == 2'b00));

  // R10: a poll acknowledge only follows an armed read with a winner
  a_r10_poll_src: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> $past(sel && rd && poll_armed && poll_hit));

  // R13: no strobe without chip select
  a_r13_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel) |-> !(init_pulse || cmd_stb || poll_ack));

endmodule

// File: tb/sim_intc_cmd_regs.sv
module sim_intc_cmd_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, rd = 0, a0 = 0;
  logic [7:0] wdata = 0, req_reg = 0, isr_reg = 0;
  logic poll_hit = 0;
  logic [2:0] poll_line = 0, ack_line = 0;
  logic [7:0] rdata, ack_vec, mask, vec_base;
  logic init_pulse, cmd_stb, poll_ack, fnest, auto_eoi, read_isr, spec_mask, poll_armed;
  logic [2:0] cmd_code, cmd_level, poll_ack_line;

  int total = 0, bad = 0;
  logic s_init, s_cmd, s_pack;
  logic [2:0] s_code, s_lvl, s_pline;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_cmd_regs u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .a0(a0), .wdata(wdata),
    .rdata(rdata), .req_reg(req_reg), .isr_reg(isr_reg), .poll_hit(poll_hit),
    .poll_line(poll_line), .ack_line(ack_line), .ack_vec(ack_vec),
    .init_pulse(init_pulse), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_level(cmd_level),
    .poll_ack(poll_ack), .poll_ack_line(poll_ack_line), .mask(mask), .vec_base(vec_base),
    .fnest(fnest), .auto_eoi(auto_eoi), .read_isr(read_isr), .spec_mask(spec_mask),
    .poll_armed(poll_armed)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, rdata, it.exp);
    end
  end

  task automatic bus(input logic s, input logic w, input logic r, input logic a, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = w; rd = r; a0 = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    s_init = init_pulse; s_cmd = cmd_stb; s_code = cmd_code; s_lvl = cmd_level;
    s_pack = poll_ack; s_pline = poll_ack_line;
    sel = 0; wr = 0; rd = 0; a0 = 0; wdata = 0;
  endtask

  task automatic wrb(input logic a, input logic [7:0] d);
    bus(1, 1, 0, a, d);
  endtask

  task automatic rdb(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = 1; rd = 1; a0 = a;
    @(posedge clk);
    sb.push_back('{exp, tag});
    @(negedge clk);
    s_pack = poll_ack; s_pline = poll_ack_line;
    sel = 0; rd = 0; a0 = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 mask", mask, 8'h00);
    chk("R1 base", vec_base, 8'h00);
    chk("R1 flags", {2'b0, fnest, auto_eoi, read_isr, spec_mask, poll_armed, 1'b0}, 8'h00);

    wrb(0, 8'h11);
    chk("R2 init_pulse", {7'b0, s_init}, 8'h01);
    wrb(1, 8'h47);
    chk("R3 base", vec_base, 8'h40);
    chk("R3 mask untouched", mask, 8'h00);
    wrb(1, 8'h04);
    chk("R4 skip byte mask", mask, 8'h00);
    wrb(1, 8'h12);
    chk("R5 fnest/aeoi", {6'b0, fnest, auto_eoi}, 8'h03);
    wrb(1, 8'h5A);
    chk("R6 mask", mask, 8'h5A);
    rdb(1, 8'h5A, "R9 read mask");

    req_reg = 8'h81; isr_reg = 8'h24;
    rdb(0, 8'h81, "R9 read req");
    wrb(0, 8'h0B);
    chk("R7 read_isr set", {7'b0, read_isr}, 8'h01);
    rdb(0, 8'h24, "R9 read isr");
    wrb(0, 8'h08);
    chk("R7 read_isr kept", {7'b0, read_isr}, 8'h01);
    wrb(0, 8'h68);
    chk("R7 spec_mask set", {7'b0, spec_mask}, 8'h01);
    wrb(0, 8'h28);
    chk("R7 spec_mask kept", {7'b0, spec_mask}, 8'h01);
    wrb(0, 8'h0A);
    chk("R7 read_isr cleared", {7'b0, read_isr}, 8'h00);

    wrb(0, 8'h63);
    chk("R8 strobe", {7'b0, s_cmd}, 8'h01);
    chk("R8 code/level", {2'b0, s_code, s_lvl}, {2'b0, 3'd3, 3'd3});
    chk("R8 mask kept", mask, 8'h5A);
    @(negedge clk);
    chk("R8 one cycle", {7'b0, cmd_stb}, 8'h00);

    wrb(0, 8'h0C);
    chk("R7 poll armed", {7'b0, poll_armed}, 8'h01);
    poll_hit = 1; poll_line = 3'd5;
    rdb(1, 8'h05, "R10 poll hit");
    chk("R10 ack", {4'b0, s_pack, s_pline}, {4'b0, 1'b1, 3'd5});
    chk("R10 disarm", {7'b0, poll_armed}, 8'h00);
    rdb(0, 8'h81, "R10 normal after poll");

    wrb(0, 8'h0C);
    poll_hit = 0;
    rdb(0, 8'h07, "R10 poll miss");
    chk("R10 no ack", {7'b0, s_pack}, 8'h00);

    wrb(0, 8'h0C);
    poll_hit = 1; poll_line = 3'd2;
    @(negedge clk);
    sel = 1; rd = 1; wr = 1; a0 = 0; wdata = 8'h0C;
    @(posedge clk);
    sb.push_back('{8'h02, "R11 poll with rearm"});
    @(negedge clk);
    sel = 0; rd = 0; wr = 0; wdata = 0;
    chk("R11 stays armed", {7'b0, poll_armed}, 8'h01);
    rdb(0, 8'h02, "R11 second poll");
    chk("R11 now disarmed", {7'b0, poll_armed}, 8'h00);
    poll_hit = 0;

    ack_line = 3'd3;
    #1 chk("R12 ack_vec", ack_vec, 8'h43);

    bus(0, 1, 0, 1, 8'hFF);
    chk("R13 mask unchanged", mask, 8'h5A);
    bus(0, 1, 0, 0, 8'h10);
    chk("R13 no init", {7'b0, s_init}, 8'h00);
    bus(0, 1, 0, 0, 8'h20);
    chk("R13 no cmd", {7'b0, s_cmd}, 8'h00);

    wrb(0, 8'h10);
    chk("R2 mask cleared", mask, 8'h00);
    chk("R2 modes cleared", {6'b0, fnest, auto_eoi}, 8'h00);
    wrb(1, 8'h8F);
    chk("R3 base 2", vec_base, 8'h88);
    wrb(1, 8'h00);
    wrb(1, 8'h33);
    chk("R4 no mode byte", mask, 8'h33);
    chk("R4 modes off", {6'b0, fnest, auto_eoi}, 8'h00);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule